// File: doc/BRIEF.md
# Multi-Buffer Translation Table Walker

This block services a translation lookaside buffer miss by searching, in hardware, up to four direct-mapped translation caches that software keeps in memory. Each cache is bound to one page-size class (small or large) and to one context class (the process's private context, or a shared context used by a group of processes mapping the same memory at the same virtual address). A separate bank of four cache descriptors serves kernel-mode misses.

A miss request carries the virtual address, the private context number, the shared context number, a flag saying whether the shared context is active, and a kernel flag. The walker probes the eligible caches one after another through a single memory read port that returns 128-bit tag/data entries. The first tag that matches both the virtual page and the right context number ends the walk with a one-cycle fill pulse carrying the entry's data word. If nothing matches, it raises a one-cycle trap pulse so software can run its own lookup. Only one walk runs at a time, and `busy` holds off new requests.

Top module: `tsb_walker`

## Requirements
- R1: After reset `busy`, `rd_req`, `fill_valid` and `trap_valid` are all low.
- R2: A request is taken when `miss_valid` is high and `busy` is low; `busy` is high from the next cycle until the cycle in which the fill or trap pulse appears, and requests presented while `busy` is high are ignored.
- R3: Slots are probed in this fixed order: 0 private small-page, 1 private large-page, 2 shared small-page, 3 shared large-page; the first hit ends the walk and no later slot is read.
- R4: A slot whose descriptor valid bit is clear issues no memory read; slots 2 and 3 are also skipped without a read when the request's shared flag is low.
- R5: The read address for a slot is base + ((VA >> shift) & (2^log2n - 1)) * 16, using that slot's descriptor.
- R6: An entry is bits [127:64] tag and [63:0] data; the tag holds the virtual page number (VA >> shift) in bits [47:0], the context in bits [60:48], and bits [63:61] must be zero. A hit needs the page number and the context to match, where slots 0 and 1 use the private context and slots 2 and 3 the shared one.
- R7: On a hit, `fill_valid` pulses for one cycle in the cycle after `rd_valid`, with `fill_data` equal to the entry's data word and `fill_slot` the slot number.
- R8: When no eligible slot hits, `trap_valid` pulses for one cycle, and never together with `fill_valid`.
- R9: A request with `miss_kernel` high uses descriptors 4 to 7 (slot plus 4); otherwise descriptors 0 to 3.
- R10: At most one read is outstanding: `rd_req` is a one-cycle pulse and no further read is issued until `rd_valid` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Miss request present |
| miss_va | input | VA_W | Faulting virtual address |
| miss_ctx | input | CTX_W | Private context number |
| miss_shr_ctx | input | CTX_W | Shared context number |
| miss_shr_en | input | 1 | Shared context active |
| miss_kernel | input | 1 | Selects kernel descriptor bank |
| busy | output | 1 | Walk in progress |
| cfg_base | input | 8 x ADDR_W | Byte base address per descriptor |
| cfg_log2n | input | 8 x 5 | log2 of entry count per descriptor |
| cfg_shift | input | 8 x 6 | Page shift of the size class per descriptor |
| cfg_valid | input | 8 | Descriptor enable |
| rd_req | output | 1 | Memory read strobe |
| rd_addr | output | ADDR_W | Memory read byte address |
| rd_valid | input | 1 | Read data returned |
| rd_data | input | 128 | Entry: tag in upper half, data in lower |
| fill_valid | output | 1 | Hit result pulse |
| fill_data | output | 64 | Data word of the hit entry |
| fill_slot | output | 2 | Slot that hit |
| trap_valid | output | 1 | All eligible slots missed |

## Verification
The bench places an entry that matches in both slot 0 and slot 2, so a walker that kept searching after a hit or probed in the wrong order would return the shared data or issue an extra read. An entry holding the shared context number in a private slot, and an address that aliases onto the same index with a different page number, catch a walker that compared the wrong context or trusted the index instead of the tag. Disabled descriptors, the shared flag held low and the kernel bank show whether a walker reads memory it must skip or reads the wrong bank. A request raised in the middle of a walk shows whether busy really holds off new work.

// File: rtl/tsbw_pkg.sv
package tsbw_pkg;
  localparam int NSLOT  = 4;
  localparam int SH_W   = 6;
  localparam int LGN_W  = 5;
  localparam int SLOT_W = 2;

  typedef enum logic [1:0] {ST_IDLE, ST_PROBE, ST_WAIT} walk_st_e;

  // Byte offset of the entry selected by a virtual address in one buffer.
  function automatic logic [63:0] entry_off(logic [63:0] va, logic [SH_W-1:0] sh,
                                            logic [LGN_W-1:0] lg);
    logic [63:0] idx;
    idx = (va >> sh) & ((64'd1 << lg) - 64'd1);
    return idx << 4;
  endfunction

  // Virtual page number for a page-size class.
  function automatic logic [63:0] page_num(logic [63:0] va, logic [SH_W-1:0] sh);
    return va >> sh;
  endfunction
endpackage

// File: rtl/tsbw_slot_sel.sv
module tsbw_slot_sel
  import tsbw_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int CTX_W  = 13,
  localparam int NCFG  = 2 * NSLOT
) (
  input  logic [NCFG-1:0][ADDR_W-1:0] cfg_base,
  input  logic [NCFG-1:0][LGN_W-1:0]  cfg_log2n,
  input  logic [NCFG-1:0][SH_W-1:0]   cfg_shift,
  input  logic [NCFG-1:0]             cfg_valid,
  input  logic                        kernel,
  input  logic                        shr_en,
  input  logic [CTX_W-1:0]            priv_ctx,
  input  logic [CTX_W-1:0]            shr_ctx,
  input  logic [SLOT_W-1:0]           slot,
  output logic [ADDR_W-1:0]           sel_base,
  output logic [LGN_W-1:0]            sel_log2n,
  output logic [SH_W-1:0]             sel_shift,
  output logic [CTX_W-1:0]            sel_ctx,
  output logic                        sel_en
);
  logic [NSLOT-1:0]            slot_en;
  logic [NSLOT-1:0][CTX_W-1:0] slot_ctx;
  logic [SLOT_W:0]             cfg_idx;

  assign cfg_idx = {kernel, slot};

  // Upper half of the slots belongs to the shared context class.
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    localparam bit IS_SHARED = (s >= NSLOT / 2);
    if (IS_SHARED) begin : g_shr
      assign slot_ctx[s] = shr_ctx;
      assign slot_en[s]  = cfg_valid[{kernel, SLOT_W'(s)}] && shr_en;
    end else begin : g_prv
      assign slot_ctx[s] = priv_ctx;
      assign slot_en[s]  = cfg_valid[{kernel, SLOT_W'(s)}];
    end
  end

  assign sel_base  = cfg_base[cfg_idx];
  assign sel_log2n = cfg_log2n[cfg_idx];
  assign sel_shift = cfg_shift[cfg_idx];
  assign sel_ctx   = slot_ctx[slot];
  assign sel_en    = slot_en[slot];
endmodule

// File: rtl/tsbw_addr_gen.sv
module tsbw_addr_gen
  import tsbw_pkg::*;
#(
  parameter int VA_W   = 48,
  parameter int ADDR_W = 40
) (
  input  logic [VA_W-1:0]   va,
  input  logic [ADDR_W-1:0] base,
  input  logic [SH_W-1:0]   shift,
  input  logic [LGN_W-1:0]  log2n,
  output logic [ADDR_W-1:0] addr
);
  assign addr = base + ADDR_W'(entry_off(64'(va), shift, log2n));
endmodule

// File: rtl/tsbw_tag_cmp.sv
module tsbw_tag_cmp
  import tsbw_pkg::*;
#(
  parameter int VA_W  = 48,
  parameter int CTX_W = 13,
  localparam int RSV_W = 64 - VA_W - CTX_W
) (
  input  logic [127:0]     entry,
  input  logic [VA_W-1:0]  va,
  input  logic [SH_W-1:0]  shift,
  input  logic [CTX_W-1:0] ctx,
  output logic             hit
);
  logic [63:0]      tag;
  logic [VA_W-1:0]  tag_vpn;
  logic [CTX_W-1:0] tag_ctx;
  logic [RSV_W-1:0] tag_rsv;

  assign tag     = entry[127:64];
  assign tag_vpn = tag[VA_W-1:0];
  assign tag_ctx = tag[VA_W +: CTX_W];
  assign tag_rsv = tag[63 -: RSV_W];

  assign hit = (tag_rsv == '0) && (tag_ctx == ctx) &&
               (64'(tag_vpn) == page_num(64'(va), shift));
endmodule

// File: rtl/tsb_walker.sv
module tsb_walker
  import tsbw_pkg::*;
#(
  parameter int VA_W   = 48,
  parameter int CTX_W  = 13,
  parameter int ADDR_W = 40,
  localparam int NCFG  = 2 * NSLOT
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        miss_valid,
  input  logic [VA_W-1:0]             miss_va,
  input  logic [CTX_W-1:0]            miss_ctx,
  input  logic [CTX_W-1:0]            miss_shr_ctx,
  input  logic                        miss_shr_en,
  input  logic                        miss_kernel,
  output logic                        busy,
  input  logic [NCFG-1:0][ADDR_W-1:0] cfg_base,
  input  logic [NCFG-1:0][LGN_W-1:0]  cfg_log2n,
  input  logic [NCFG-1:0][SH_W-1:0]   cfg_shift,
  input  logic [NCFG-1:0]             cfg_valid,
  output logic                        rd_req,
  output logic [ADDR_W-1:0]           rd_addr,
  input  logic                        rd_valid,
  input  logic [127:0]                rd_data,
  output logic                        fill_valid,
  output logic [63:0]                 fill_data,
  output logic [SLOT_W-1:0]           fill_slot,
  output logic                        trap_valid
);
  walk_st_e          state;
  logic [SLOT_W-1:0] slot;
  logic [VA_W-1:0]   q_va;
  logic [CTX_W-1:0]  q_ctx, q_shr_ctx;
  logic              q_shr_en, q_kernel;

  logic [ADDR_W-1:0] sel_base;
  logic [LGN_W-1:0]  sel_log2n;
  logic [SH_W-1:0]   sel_shift;
  logic [CTX_W-1:0]  sel_ctx;
  logic              sel_en;
  logic              entry_hit;

  // Named internal events.
  logic accept, waiting, last_slot, probe_hit, probe_miss, skip_slot;
  assign accept     = miss_valid && (state == ST_IDLE);
  assign waiting    = (state == ST_WAIT);
  assign last_slot  = (slot == SLOT_W'(NSLOT - 1));
  assign probe_hit  = waiting && rd_valid && entry_hit;
  assign probe_miss = waiting && rd_valid && !entry_hit;
  assign skip_slot  = (state == ST_PROBE) && !sel_en;

  tsbw_slot_sel #(.ADDR_W(ADDR_W), .CTX_W(CTX_W)) u_sel (
    .cfg_base(cfg_base), .cfg_log2n(cfg_log2n), .cfg_shift(cfg_shift),
    .cfg_valid(cfg_valid), .kernel(q_kernel), .shr_en(q_shr_en),
    .priv_ctx(q_ctx), .shr_ctx(q_shr_ctx), .slot(slot),
    .sel_base(sel_base), .sel_log2n(sel_log2n), .sel_shift(sel_shift),
    .sel_ctx(sel_ctx), .sel_en(sel_en)
  );

  tsbw_addr_gen #(.VA_W(VA_W), .ADDR_W(ADDR_W)) u_addr (
    .va(q_va), .base(sel_base), .shift(sel_shift), .log2n(sel_log2n),
    .addr(rd_addr)
  );

  tsbw_tag_cmp #(.VA_W(VA_W), .CTX_W(CTX_W)) u_cmp (
    .entry(rd_data), .va(q_va), .shift(sel_shift), .ctx(sel_ctx),
    .hit(entry_hit)
  );

  assign busy   = (state != ST_IDLE);
  assign rd_req = (state == ST_PROBE) && sel_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      slot       <= '0;
      q_va       <= '0;
      q_ctx      <= '0;
      q_shr_ctx  <= '0;
      q_shr_en   <= 1'b0;
      q_kernel   <= 1'b0;
      fill_valid <= 1'b0;
      fill_data  <= '0;
      fill_slot  <= '0;
      trap_valid <= 1'b0;
    end else begin
      fill_valid <= 1'b0;
      trap_valid <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          q_va      <= miss_va;
          q_ctx     <= miss_ctx;
          q_shr_ctx <= miss_shr_ctx;
          q_shr_en  <= miss_shr_en;
          q_kernel  <= miss_kernel;
          slot      <= '0;
          state     <= ST_PROBE;
        end
        ST_PROBE: begin
          if (sel_en) begin
            state <= ST_WAIT;
          end else if (last_slot) begin
            trap_valid <= 1'b1;
            state      <= ST_IDLE;
          end else begin
            slot <= slot + 1'b1;
          end
        end
        ST_WAIT: begin
          if (probe_hit) begin
            fill_valid <= 1'b1;
            fill_data  <= rd_data[63:0];
            fill_slot  <= slot;
            state      <= ST_IDLE;
          end else if (probe_miss) begin
            if (last_slot) begin
              trap_valid <= 1'b1;
              state      <= ST_IDLE;
            end else begin
              slot  <= slot + 1'b1;
              state <= ST_PROBE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tsbw_chk.sv
module tsbw_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       miss_valid,
  input logic       rd_req,
  input logic       rd_valid,
  input logic       fill_valid,
  input logic       trap_valid,
  input logic       waiting,
  input logic [1:0] cur_slot
);
  // R2
  take_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && !busy) |=> busy);

  // R10
  read_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> (!rd_req && waiting));

  // R3
  slot_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || cur_slot >= $past(cur_slot)));

  // R7
  fill_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> $past(rd_valid));

  // R8
  fill_trap_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_valid && trap_valid));

  // R8
  trap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> !trap_valid);
endmodule

bind tsb_walker tsbw_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .miss_valid(miss_valid),
  .rd_req(rd_req), .rd_valid(rd_valid), .fill_valid(fill_valid),
  .trap_valid(trap_valid), .waiting(waiting), .cur_slot(slot)
);

// File: tb/tsb_walker_tb.sv
module tsb_walker_tb;
  localparam int VA_W = 48, CTX_W = 13, ADDR_W = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic              miss_valid = 0, miss_shr_en = 0, miss_kernel = 0;
  logic [VA_W-1:0]   miss_va = '0;
  logic [CTX_W-1:0]  miss_ctx = '0, miss_shr_ctx = '0;
  logic              busy, rd_req, rd_valid = 0, fill_valid, trap_valid;
  logic [ADDR_W-1:0] rd_addr;
  logic [127:0]      rd_data = '0;
  logic [63:0]       fill_data;
  logic [1:0]        fill_slot;
  logic [7:0][ADDR_W-1:0] cfg_base;
  logic [7:0][4:0]        cfg_log2n;
  logic [7:0][5:0]        cfg_shift;
  logic [7:0]             cfg_valid;

  tsb_walker #(.VA_W(VA_W), .CTX_W(CTX_W), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_va(miss_va),
    .miss_ctx(miss_ctx), .miss_shr_ctx(miss_shr_ctx), .miss_shr_en(miss_shr_en),
    .miss_kernel(miss_kernel), .busy(busy), .cfg_base(cfg_base),
    .cfg_log2n(cfg_log2n), .cfg_shift(cfg_shift), .cfg_valid(cfg_valid),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .fill_valid(fill_valid), .fill_data(fill_data), .fill_slot(fill_slot),
    .trap_valid(trap_valid)
  );

  int total = 0, bad = 0, cycles = 0, lat = 1, pend = 0;
  logic [127:0] mem [logic [ADDR_W-1:0]];
  logic [ADDR_W-1:0] exp_q[$];
  logic [ADDR_W-1:0] pend_addr;
  bit   exp_hit, done, mon_on = 0;
  logic [63:0] exp_data;
  int   exp_slot;
  string tag_now = "";

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Reference address arithmetic, restated with division and modulo.
  function automatic longint unsigned ref_addr(int d, longint unsigned va);
    longint unsigned pg, idx;
    pg  = va / (64'd1 << cfg_shift[d]);
    idx = pg % (64'd1 << cfg_log2n[d]);
    return longint'(cfg_base[d]) + idx * 16;
  endfunction

  task automatic place(int d, longint unsigned va, int ctx, logic [63:0] data);
    logic [63:0] tag;
    tag = (longint'(ctx) << 48) | (va / (64'd1 << cfg_shift[d]));
    mem[ADDR_W'(ref_addr(d, va))] = {tag, data};
  endtask

  // Behavioural model of one walk: list of reads and the final outcome.
  task automatic predict(longint unsigned va, int pctx, int sctx, bit sen, bit kern);
    exp_q.delete();
    exp_hit = 0;
    for (int s = 0; s < 4; s++) begin
      int d, want;
      logic [ADDR_W-1:0] a;
      logic [127:0] e;
      d = s + (kern ? 4 : 0);
      if (!cfg_valid[d] || (s >= 2 && !sen)) continue;
      a = ADDR_W'(ref_addr(d, va));
      exp_q.push_back(a);
      e = mem.exists(a) ? mem[a] : '0;
      want = (s >= 2) ? sctx : pctx;
      if (e[127:64] == ((longint'(want) << 48) | (va / (64'd1 << cfg_shift[d])))) begin
        exp_hit = 1; exp_data = e[63:0]; exp_slot = s;
        break;
      end
    end
  endtask

  // Per-clock comparison and memory responder.
  always @(negedge clk) begin
    cycles++;
    if (rd_valid) rd_valid <= 0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        rd_valid <= 1;
        rd_data  <= mem.exists(pend_addr) ? mem[pend_addr] : '0;
      end
    end
    if (mon_on) begin
      if (rd_req) begin
        if (exp_q.size() == 0) check(0, "R4", {tag_now, " unexpected read"}, longint'(rd_addr), 0);
        else begin
          logic [ADDR_W-1:0] ea;
          ea = exp_q.pop_front();
          // R3 R5: next read in the expected order and at the expected address
          check(rd_addr == ea, "R5", {tag_now, " read address"}, longint'(rd_addr), longint'(ea));
        end
        pend_addr = rd_addr; pend = lat;
      end
      if (fill_valid || trap_valid) begin
        check(fill_valid == exp_hit, exp_hit ? "R7" : "R8", {tag_now, " outcome"}, fill_valid, exp_hit);
        check(exp_q.size() == 0, "R3", {tag_now, " reads left"}, exp_q.size(), 0);
        if (fill_valid && exp_hit) begin
          check(fill_data == exp_data, "R7", {tag_now, " data"}, fill_data, exp_data);
          check(fill_slot == 2'(exp_slot), "R3", {tag_now, " slot"}, fill_slot, exp_slot);
        end
        done = 1;
      end
    end
  end

  task automatic walk(string name, longint unsigned va, int pctx, int sctx, bit sen,
                      bit kern, bit poke = 0);
    int n;
    tag_now = name;
    predict(va, pctx, sctx, sen, kern);
    done = 0;
    @(negedge clk);
    check(!busy, "R2", {name, " idle before"}, busy, 0);
    miss_valid = 1; miss_va = VA_W'(va); miss_ctx = CTX_W'(pctx);
    miss_shr_ctx = CTX_W'(sctx); miss_shr_en = sen; miss_kernel = kern;
    @(negedge clk);
    miss_valid = 0;
    if (!done) check(busy, "R2", {name, " busy after take"}, busy, 1);
    if (poke && !done) begin
      // R2: a second request during the walk must be ignored
      miss_valid = 1; miss_va = VA_W'(va ^ 48'h1234_5678_0000); miss_kernel = 1;
      @(negedge clk); @(negedge clk);
      miss_valid = 0;
    end
    n = 0;
    while (!done && n < 200) begin @(negedge clk); n++; end
    check(done, "R8", {name, " walk ended"}, done, 1);
    repeat (4) @(negedge clk);
    check(!busy && !rd_req, "R2", {name, " idle after"}, busy, 0);
  endtask

  initial begin
    for (int k = 0; k < 8; k++) begin
      cfg_base[k]  = ADDR_W'(40'h10_0000 * (k + 1));
      cfg_log2n[k] = (k < 4) ? ((k % 2) ? 5'd3 : 5'd4) : 5'd5;
      cfg_shift[k] = (k % 2) ? 6'd22 : 6'd13;
    end
    cfg_valid = 8'hFF;
    repeat (3) @(negedge clk);
    // R1
    check(!busy && !rd_req && !fill_valid && !trap_valid, "R1", "reset outputs",
          {busy, rd_req, fill_valid, trap_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    check(!busy && !fill_valid && !trap_valid, "R1", "after release", busy, 0);
    mon_on = 1;

    // R6 R7: private small-page hit on the first probe
    place(0, 48'h0012_3456_6000, 5, 64'hA0);
    walk("t_prv_small", 48'h0012_3456_6000, 5, 9, 0, 0);
    // R3: private large-page hit after a small-page miss
    lat = 3;
    place(1, 48'h0055_0040_0000, 5, 64'hA1);
    walk("t_prv_large", 48'h0055_0040_0000, 5, 9, 0, 0);
    // R6: shared slot compares the shared context; private slot holds wrong one
    place(0, 48'h0077_0000_2000, 9, 64'hB0);
    place(2, 48'h0077_0000_2000, 9, 64'hA2);
    walk("t_shared", 48'h0077_0000_2000, 5, 9, 1, 0);
    // R4: same request with shared flag low reads only slots 0 and 1
    walk("t_shr_off", 48'h0077_0000_2000, 5, 9, 0, 0);
    // R3: both slot 0 and slot 2 match, slot 0 wins
    lat = 1;
    place(0, 48'h0033_0000_8000, 7, 64'hC0);
    place(2, 48'h0033_0000_8000, 7, 64'hC2);
    walk("t_priority", 48'h0033_0000_8000, 7, 7, 1, 0);
    // R5 R6: alias onto same index, different page number, misses everywhere
    walk("t_alias", 48'h0033_0000_8000 + (48'd16 << 13), 7, 7, 1, 0);
    // R4: disabled slot 0 not read, slot 1 hits
    cfg_valid[0] = 0;
    place(1, 48'h0044_00C0_0000, 3, 64'hD1);
    walk("t_skip", 48'h0044_00C0_0000, 3, 0, 0, 0);
    // R4 R8: no enabled slot, trap without any read
    cfg_valid[3:0] = 4'h0;
    walk("t_none", 48'h0044_00C0_0000, 3, 0, 1, 0);
    cfg_valid = 8'hFF;
    // R9: kernel bank, hit in shared large-page slot
    lat = 2;
    place(7, 48'h0066_0100_0000, 11, 64'hE7);
    walk("t_kernel", 48'h0066_0100_0000, 4, 11, 1, 1);
    // R9: the same address in the user bank misses
    walk("t_user_bank", 48'h0066_0100_0000, 4, 11, 1, 0);
    // R2 R10: request raised mid-walk is ignored
    lat = 4;
    walk("t_hold", 48'h0012_3456_6000, 5, 9, 1, 0, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    bad++; total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule